// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-up to the point where it can take its first ACTIVE command. After a synchronous reset it first lets the device settle: it drives only NOP commands for a long interval. It then closes all banks with one precharge, runs two auto-refresh cycles and writes a mode code into the device's mode register. Once the last required gap has elapsed it raises a done flag. The flag tells the main memory controller that it may take over the command pins.

All waits are given to the block as elaboration-time parameters in nanoseconds, together with the clock period in nanoseconds. The mode-register gap is the exception and is given in clocks. The block turns each nanosecond wait into a whole number of clock cycles. One state machine and a single shared down-counter step through the fixed command order. Every output pin comes from a register.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: NOP on the command pins ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `sd_cke` low, every `sd_dqm` bit high, `sd_addr` and `sd_ba` zero, and `init_done` low.
- R2: Call the first clock edge with `rst` low cycle 1. From cycle 1 on, `sd_cke` is high. Cycles 1 to N_STABLE carry only NOP, where N_STABLE is the converted settle time. This puts CKE high at least one full cycle before the first command that is not a NOP.
- R3: In cycle N_STABLE+1 the command is PRECHARGE (4'b0010). `sd_addr` carries bit PRE_ALL_BIT (default 10) high and all other bits low, and `sd_ba` is zero.
- R4: Exactly N_RP NOP cycles follow the PRECHARGE. The first AUTO REFRESH comes in the cycle after them.
- R5: Two AUTO REFRESH commands (4'b0001) are issued, with `sd_addr` and `sd_ba` zero. Each is followed by exactly N_RFC NOP cycles.
- R6: The cycle after the second refresh gap carries LOAD MODE (4'b0000). `sd_addr` equals `mode_word` and `sd_ba` equals `mode_bank`, both as sampled at the clock edge that launches the command.
- R7: After LOAD MODE, exactly N_MRD NOP cycles pass (N_MRD = T_MRD_CK, at least 1). `init_done` is high in the next cycle. From then until reset, `init_done` stays high and the command stays NOP.
- R8: `sd_dqm` is all ones in every cycle where `init_done` is low, and all zeros once `init_done` is high.
- R9: A synchronous reset at any point, including mid-sequence or after done, returns the outputs to the R1 values at the next edge. The sequence then starts over from the settle wait.
- R10: Each nanosecond wait converts to ceil(t_ns / CLK_PERIOD_NS) cycles, with a floor of 1 cycle. This covers a parameter of 0 or one shorter than a clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_word | input | ADDR_W | Mode code placed on the address pins during LOAD MODE |
| mode_bank | input | BA_W | Bank-address value placed on the bank pins during LOAD MODE |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Data mask, high during initialization so the data pins stay in high impedance |
| sd_addr | output | ADDR_W | Address pins |
| sd_ba | output | BA_W | Bank-address pins |
| init_done | output | 1 | High once the device may take an ACTIVE command |

## Verification
The bench builds two copies of the block side by side, both at a 5 ns clock. The first uses a settle time of 997 ns (200 cycles, a rounding-up case), tRP = 18 ns (4 cycles), tRFC = 66 ns (14 cycles) and a 2-clock mode gap. This makes the whole sequence short enough to walk cycle by cycle many times, with random mode codes and resets at random points. The second copy uses 3 ns settle, 0 ns tRP, 5 ns tRFC and a 1-clock mode gap. Every wait therefore collapses to its 1-cycle floor, which exercises the back-to-back command spacing and the ceiling rule at both of its edges.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LOADMODE = 4'b0000,
    CMD_AREF     = 4'b0001,
    CMD_PREALL   = 4'b0010,
    CMD_NOP      = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_PRE,
    ST_GAP_RP,
    ST_REF_A,
    ST_GAP_RFC_A,
    ST_REF_B,
    ST_GAP_RFC_B,
    ST_LOADMODE,
    ST_GAP_MRD,
    ST_READY
  } init_st_e;

  // Nanosecond wait to clock cycles, rounded up, never below one
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_interval_counter.sv
module init_interval_counter #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CNT_W'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_driver.sv
module init_cmd_driver
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int DQM_W       = 2,
  parameter int PRE_ALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  init_st_e          st,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [BA_W-1:0]   mode_bank,
  output logic [3:0]        cmd_pins,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ALL_BANKS_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

  sd_cmd_e           cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    ba_d   = '0;
    unique case (st)
      ST_PRE: begin
        cmd_d  = CMD_PREALL;
        addr_d = ALL_BANKS_ADDR;
      end
      ST_REF_A, ST_REF_B: cmd_d = CMD_AREF;
      ST_LOADMODE: begin
        cmd_d  = CMD_LOADMODE;
        addr_d = mode_word;
        ba_d   = mode_bank;
      end
      default: cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pins <= CMD_NOP;
      cke      <= 1'b0;
      dqm      <= '1;
      addr     <= '0;
      ba       <= '0;
      done     <= 1'b0;
    end else begin
      cmd_pins <= cmd_d;
      cke      <= 1'b1;
      dqm      <= {DQM_W{st != ST_READY}};
      addr     <= addr_d;
      ba       <= ba_d;
      done     <= (st == ST_READY);
    end
  end

  // R2: clock enable already high in the cycle before any real command
  p_cke_lead_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins != CMD_NOP) |-> (cke && $past(cke)));

  // R3: precharge closes every bank
  p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == CMD_PREALL) |-> (addr == ALL_BANKS_ADDR && ba == '0));

  // R4: a NOP always follows the precharge
  p_pre_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == CMD_PREALL) |=> (cmd_pins == CMD_NOP));

  // R5: a NOP always follows a refresh
  p_ref_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == CMD_AREF) |=> (cmd_pins == CMD_NOP));

  // R6: mode payload is the code present at the launching edge
  p_mode_payload_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_pins == CMD_LOADMODE) |-> (addr == $past(mode_word) && ba == $past(mode_bank)));

  // R7: done is sticky and only NOPs follow it
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd_pins == CMD_NOP));

  // R8: mask released exactly when done rises
  p_dqm_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (dqm == '0 && $past(dqm) == '1));

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_STABLE_NS   = 100000,
  parameter int T_RP_NS       = 20,
  parameter int T_RFC_NS      = 70,
  parameter int T_MRD_CK      = 2,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter int PRE_ALL_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic [BA_W-1:0]   mode_bank,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done
);

  localparam int N_STABLE = ns_to_cycles(T_STABLE_NS, CLK_PERIOD_NS);
  localparam int N_RP     = ns_to_cycles(T_RP_NS, CLK_PERIOD_NS);
  localparam int N_RFC    = ns_to_cycles(T_RFC_NS, CLK_PERIOD_NS);
  localparam int N_MRD    = (T_MRD_CK < 1) ? 1 : T_MRD_CK;
  localparam int N_MAX    = max_int(max_int(N_STABLE, N_RP), max_int(N_RFC, N_MRD));
  localparam int CNT_W    = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(N_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(N_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(N_MRD - 1);

  init_st_e         st_q, st_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             cnt_zero;
  logic [3:0]       cmd_pins;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_SETTLE:    if (cnt_zero) st_d = ST_PRE;
      ST_PRE:       begin st_d = ST_GAP_RP;    ld = 1'b1; ld_val = LD_RP;  end
      ST_GAP_RP:    if (cnt_zero) st_d = ST_REF_A;
      ST_REF_A:     begin st_d = ST_GAP_RFC_A; ld = 1'b1; ld_val = LD_RFC; end
      ST_GAP_RFC_A: if (cnt_zero) st_d = ST_REF_B;
      ST_REF_B:     begin st_d = ST_GAP_RFC_B; ld = 1'b1; ld_val = LD_RFC; end
      ST_GAP_RFC_B: if (cnt_zero) st_d = ST_LOADMODE;
      ST_LOADMODE:  begin st_d = ST_GAP_MRD;   ld = 1'b1; ld_val = LD_MRD; end
      ST_GAP_MRD:   if (cnt_zero) st_d = ST_READY;
      ST_READY:     st_d = ST_READY;
      default:      st_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_SETTLE;
    else     st_q <= st_d;
  end

  init_interval_counter #(
    .CNT_W   (CNT_W),
    .RST_VAL (N_STABLE - 1)
  ) u_gap_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (cnt_zero)
  );

  init_cmd_driver #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .DQM_W       (DQM_W),
    .PRE_ALL_BIT (PRE_ALL_BIT)
  ) u_drv (
    .clk       (clk),
    .rst       (rst),
    .st        (st_q),
    .mode_word (mode_word),
    .mode_bank (mode_bank),
    .cmd_pins  (cmd_pins),
    .cke       (sd_cke),
    .dqm       (sd_dqm),
    .addr      (sd_addr),
    .ba        (sd_ba),
    .done      (init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;

  // R4/R5/R7: a wait state is not left while the shared counter is still running
  p_gap_held_r4: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_GAP_RP || st_q == ST_GAP_RFC_A || st_q == ST_GAP_RFC_B ||
      st_q == ST_GAP_MRD) && !cnt_zero) |=> (st_q == $past(st_q)));

  // R9: the ready state is only left through reset
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_READY) |=> (st_q == ST_READY));

endmodule

// File: tb/sdram_powerup_seq_tb.sv
`timescale 1ns/1ps
module sdram_powerup_seq_tb;

  localparam int CLK_NS = 5;
  localparam int OBS_W  = 22;

  // main build
  localparam int A_STABLE = 997, A_RP = 18, A_RFC = 66, A_MRD = 2;
  // floor build
  localparam int B_STABLE = 3, B_RP = 0, B_RFC = 5, B_MRD = 1;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mode_word = '0;
  logic [1:0]  mode_bank = '0;
  bit          sel = 1'b0;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_done;
  logic [1:0] a_dqm, a_ba;
  logic [11:0] a_addr;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_done;
  logic [1:0] b_dqm, b_ba;
  logic [11:0] b_addr;

  sdram_powerup_seq #(
    .CLK_PERIOD_NS(CLK_NS), .T_STABLE_NS(A_STABLE), .T_RP_NS(A_RP),
    .T_RFC_NS(A_RFC), .T_MRD_CK(A_MRD)
  ) u_dut (
    .clk(clk), .rst(rst), .mode_word(mode_word), .mode_bank(mode_bank),
    .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas), .sd_we_n(a_we),
    .sd_cke(a_cke), .sd_dqm(a_dqm), .sd_addr(a_addr), .sd_ba(a_ba),
    .init_done(a_done)
  );

  sdram_powerup_seq #(
    .CLK_PERIOD_NS(CLK_NS), .T_STABLE_NS(B_STABLE), .T_RP_NS(B_RP),
    .T_RFC_NS(B_RFC), .T_MRD_CK(B_MRD)
  ) u_dut_min (
    .clk(clk), .rst(rst), .mode_word(mode_word), .mode_bank(mode_bank),
    .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas), .sd_we_n(b_we),
    .sd_cke(b_cke), .sd_dqm(b_dqm), .sd_addr(b_addr), .sd_ba(b_ba),
    .init_done(b_done)
  );

  wire [OBS_W-1:0] obs_a = {a_done, a_dqm, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
  wire [OBS_W-1:0] obs_b = {b_done, b_dqm, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};
  wire [OBS_W-1:0] obs   = sel ? obs_b : obs_a;

  // R10: bench-side conversion, rounded up with a one-cycle floor
  function automatic int exp_cyc(input int t_ns);
    int c;
    c = (t_ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [OBS_W-1:0] pack(input logic done, input logic cke,
      input logic [3:0] cmd, input logic [1:0] ba, input logic [11:0] a);
    return {done, {2{~done}}, cke, cmd, ba, a};
  endfunction

  task automatic check_obs(input string req, input logic [OBS_W-1:0] exp);
    checks++;
    if (obs !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, obs, exp);
    end
  endtask

  // abort_at = 0 runs to completion; otherwise reset is applied after cycle abort_at
  task automatic run_seq(input bit s, input int ns, input int nrp, input int nrfc,
                         input int nmrd, input int abort_at);
    int m_pre, m_r1, m_r2, m_lmr, m_done;
    logic [OBS_W-1:0] e;
    string tag;
    sel = s;
    @(negedge clk);
    rst = 1'b1;
    mode_word = 12'($urandom);
    mode_bank = 2'($urandom);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_obs("R1 reset state", pack(1'b0, 1'b0, NOP, 2'b00, 12'h000));
    m_pre  = ns + 1;
    m_r1   = m_pre + nrp + 1;
    m_r2   = m_r1 + nrfc + 1;
    m_lmr  = m_r2 + nrfc + 1;
    m_done = m_lmr + nmrd + 1;
    rst = 1'b0;
    for (int m = 1; m <= m_done + 3; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (abort_at == m) begin
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_obs("R9 mid-run reset", pack(1'b0, 1'b0, NOP, 2'b00, 12'h000));
        return;
      end
      if (m < m_pre) begin
        tag = "R2 settle NOPs"; e = pack(1'b0, 1'b1, NOP, 2'b00, 12'h000);
      end else if (m == m_pre) begin
        tag = "R3 precharge all"; e = pack(1'b0, 1'b1, PRE, 2'b00, 12'h400);
      end else if (m < m_r1) begin
        tag = "R4 tRP gap"; e = pack(1'b0, 1'b1, NOP, 2'b00, 12'h000);
      end else if (m == m_r1 || m == m_r2) begin
        tag = "R5 refresh"; e = pack(1'b0, 1'b1, REF, 2'b00, 12'h000);
      end else if (m < m_lmr) begin
        tag = "R5 tRFC gap"; e = pack(1'b0, 1'b1, NOP, 2'b00, 12'h000);
      end else if (m == m_lmr) begin
        tag = "R6 load mode"; e = pack(1'b0, 1'b1, LMR, mode_bank, mode_word);
      end else if (m < m_done) begin
        tag = "R7 tMRD gap, R8 mask held"; e = pack(1'b0, 1'b1, NOP, 2'b00, 12'h000);
      end else begin
        tag = "R7 done sticky, R8 mask released"; e = pack(1'b1, 1'b1, NOP, 2'b00, 12'h000);
      end
      if (s) tag = {"R10 floor build: ", tag};
      check_obs(tag, e);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int na, ra, fa, nb, rb, fb;
    void'($urandom(32'd7531));
    na = exp_cyc(A_STABLE); ra = exp_cyc(A_RP); fa = exp_cyc(A_RFC);
    nb = exp_cyc(B_STABLE); rb = exp_cyc(B_RP); fb = exp_cyc(B_RFC);
    // R10: directed conversion corner values
    checks++;
    if (na != 200 || ra != 4 || fa != 14 || nb != 1 || rb != 1 || fb != 1) begin
      errors++;
      $display("FAIL R10 conversion actual=%0d,%0d,%0d,%0d,%0d,%0d expected=200,4,14,1,1,1",
               na, ra, fa, nb, rb, fb);
    end
    // directed full runs on both builds
    run_seq(1'b0, na, ra, fa, A_MRD, 0);
    run_seq(1'b1, nb, rb, fb, B_MRD, 0);
    // directed aborts: at the precharge cycle and just after done
    run_seq(1'b0, na, ra, fa, A_MRD, na + 1);
    run_seq(1'b0, na, ra, fa, A_MRD, 0);
    run_seq(1'b1, nb, rb, fb, B_MRD, 1 + 1 + 1 + 1 + 1 + 1 + 1 + 1 + 1 + 1);
    // random mode codes and random abort points
    for (int i = 0; i < 8; i++) begin
      bit s;
      int ab;
      s = 1'($urandom);
      if (s) ab = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 12);
      else   ab = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 240);
      if (s) run_seq(1'b1, nb, rb, fb, B_MRD, ab);
      else   run_seq(1'b0, na, ra, fa, A_MRD, ab);
      if (ab != 0) begin
        if (s) run_seq(1'b1, nb, rb, fb, B_MRD, 0);
        else   run_seq(1'b0, na, ra, fa, A_MRD, 0);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule